// File: doc/BRIEF.md
# Reload Down-Counter Timer with Steered Count Writes

This block is a down-counting timer with a reload register, driven by a one-cycle tick enable from an external prescaler. Software controls it through a small register port. A mode register holds a start flag, a write-steering bit and an operating-mode field. A count register is written to set the count value and is read to see the live counter. A control register holds output and trigger settings that stay at zero in plain timer mode.

While the timer runs, every tick lowers the counter by one. A tick that finds the counter at zero loads the reload value instead and raises a one-cycle interrupt request. A write to the count register always updates the reload register. It also updates the live counter unless the timer is running with the steering bit set. In that case the counter keeps running and the new value takes effect at the next underflow. Register writes take effect on the clock edge. Reads are combinational from the address.

Top module: `reload_timer`

## Requirements
- R1: After reset, address 0 and address 2 read 00h, address 1 reads 00h, and irq is low.
- R2: The mode register is at address 0. Bit 7 is the start flag (1 = run). Bit 6 is the steering bit. Bits 5:4 are the mode field, where 00 is timer mode. Bits 3:0 always read 0 and writes to them are ignored.
- R3: The control register is at address 2. Bits 7:5 are writable and read back. Bits 4:0 always read 0. The contents of this register do not affect counting.
- R4: While the start flag is 1 and the mode field is 00, each cycle with tick_en high lowers the counter by one. Reading address 1 returns the live counter.
- R5: A counted tick that finds the counter at zero loads the reload value. irq goes high in the following cycle, for one cycle per underflow.
- R6: When the start flag is 0, or the mode field is not 00, the counter holds and ticks are ignored. When the start flag is 0, a write to address 1 loads both the counter and the reload register, whatever the steering bit holds.
- R7: When the start flag is 1 and the steering bit is 0, a write to address 1 loads both the counter and the reload register.
- R8: When the start flag is 1 and the steering bit is 1, a write to address 1 loads only the reload register. The counter continues undisturbed, and the new value is used at the next underflow.
- R9: Suppose a count write and an underflow fall in the same cycle. With the steering bit at 0, the counter takes the written value. With the steering bit at 1, it takes the reload value held before that write. In both cases irq still pulses.
- R10: Address 3 reads 00h and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable, one cycle per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| irq | output | 1 | Underflow interrupt pulse |

## Verification
A wrong counter or reload value appears at address 1 on the cycle after the faulty edge. It also shifts the irq pulse by as many ticks as the error. A count write steered to the wrong register shows up in one of two ways. If the counter was wrongly loaded, the read changes at once. If the reload register was wrongly left alone, the next reload period is wrong and the irq pulse moves. A mode bit that is stored wrongly shows in the address 0 read-back. It also shows as ticks being counted or ignored from the next cycle onward.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    RA_MODE  = 2'd0,
    RA_COUNT = 2'd1,
    RA_CTRL  = 2'd2,
    RA_NONE  = 2'd3
  } rt_addr_e;

  localparam logic [1:0] MODE_TIMER = 2'b00;

  typedef struct packed {
    logic       run;
    logic       wctl;
    logic [1:0] mode;
  } rt_mode_t;

  // a count write reaches the live counter unless running with steering set
  function automatic logic hits_counter(input logic run, input logic wctl);
    return !(run && wctl);
  endfunction
endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import rt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [3:0]   wr_hi,
  input  logic [W-1:0] cnt,
  output rt_mode_t     mode_q,
  output logic         cnt_wr,
  output logic [W-1:0] rdata
);
  localparam int PAD = W - 8;

  logic [2:0] ctrl_q;
  logic       mode_wr;
  logic       ctrl_wr;

  always_comb begin
    mode_wr = bus_wr && (bus_addr == RA_MODE);
    ctrl_wr = bus_wr && (bus_addr == RA_CTRL);
    cnt_wr  = bus_wr && (bus_addr == RA_COUNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (mode_wr) mode_q <= rt_mode_t'(wr_hi);
      if (ctrl_wr) ctrl_q <= wr_hi[3:1];
    end
  end

  generate
    if (PAD > 0) begin : g_wide
      always_comb begin
        unique case (bus_addr)
          RA_MODE:  rdata = {{PAD{1'b0}}, mode_q, 4'b0000};
          RA_COUNT: rdata = cnt;
          RA_CTRL:  rdata = {{PAD{1'b0}}, ctrl_q, 5'b00000};
          default:  rdata = '0;
        endcase
      end
    end else begin : g_byte
      always_comb begin
        unique case (bus_addr)
          RA_MODE:  rdata = {mode_q, 4'b0000};
          RA_COUNT: rdata = cnt;
          RA_CTRL:  rdata = {ctrl_q, 5'b00000};
          default:  rdata = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import rt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  rt_mode_t     mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reload_q,
  output logic         run_eff,
  output logic         uf_evt,
  output logic         irq
);
  logic         tick_hit;
  logic         load_cnt;
  logic [W-1:0] cnt_nxt;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] c,
                                             input logic [W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  always_comb begin
    run_eff  = mode.run && (mode.mode == MODE_TIMER);
    tick_hit = run_eff && tick_en;
    uf_evt   = tick_hit && (cnt_q == '0);
    load_cnt = cnt_wr && hits_counter(mode.run, mode.wctl);
    if (load_cnt)      cnt_nxt = wdata;
    else if (tick_hit) cnt_nxt = step_down(cnt_q, reload_q);
    else               cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      irq      <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      irq   <= uf_evt;
      if (cnt_wr) reload_q <= wdata;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq
);
  rt_mode_t     mode_q;
  logic         cnt_wr;
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;
  logic         run_eff;
  logic         uf_evt;

  rt_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_hi    (bus_wdata[7:4]),
    .cnt      (cnt_q),
    .mode_q   (mode_q),
    .cnt_wr   (cnt_wr),
    .rdata    (bus_rdata)
  );

  rt_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .mode     (mode_q),
    .cnt_wr   (cnt_wr),
    .wdata    (bus_wdata),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .run_eff  (run_eff),
    .uf_evt   (uf_evt),
    .irq      (irq)
  );
endmodule

// File: rtl/rt_chk.sv
module rt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         cnt_wr,
  input logic [W-1:0] wdata,
  input logic         run,
  input logic         wctl,
  input logic         run_eff,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload,
  input logic         uf_evt,
  input logic         irq,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_rdata
);
  // R2
  mode_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[3:0] == 4'b0000));

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_eff && tick_en && !cnt_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !cnt_wr) |=> (cnt == $past(reload)));

  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> irq);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_evt |=> !irq);

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_eff && !cnt_wr) |=> $stable(cnt));

  // R7
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !(run && wctl)) |=> (cnt == $past(wdata) && reload == $past(wdata)));

  // R8
  reload_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && run && wctl && !tick_en) |=> ($stable(cnt) && reload == $past(wdata)));
endmodule

bind reload_timer rt_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .cnt_wr    (cnt_wr),
  .wdata     (bus_wdata),
  .run       (mode_q.run),
  .wctl      (mode_q.wctl),
  .run_eff   (run_eff),
  .cnt       (cnt_q),
  .reload    (reload_q),
  .uf_evt    (uf_evt),
  .irq       (irq),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  int m_run = 0, m_wctl = 0, m_mode = 0, m_ctrl = 0;
  int m_cnt = 0, m_rel = 0, m_irq = 0;

  always #2 clk = ~clk;

  reload_timer #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int expect_read(input int a);
    case (a)
      0: return m_run * 128 + m_wctl * 64 + m_mode * 16;
      1: return m_cnt;
      2: return m_ctrl * 32;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance model, compare after the edge
  task automatic step(input string tag, input bit wr, input int a, input int d, input bit tk);
    int nc, nr;
    bit ticking;
    bus_wr = wr; bus_addr = a[1:0]; bus_wdata = d[7:0]; tick_en = tk;
    ticking = (m_run == 1) && (m_mode == 0) && tk;
    m_irq = (ticking && m_cnt == 0) ? 1 : 0;
    nc = m_cnt; nr = m_rel;
    if (ticking) nc = (m_cnt == 0) ? m_rel : m_cnt - 1;
    if (wr && a == 1) begin
      nr = d;
      if (!(m_run == 1 && m_wctl == 1)) nc = d;
    end
    if (wr && a == 0) begin
      m_run = (d >> 7) & 1; m_wctl = (d >> 6) & 1; m_mode = (d >> 4) & 3;
    end
    if (wr && a == 2) m_ctrl = (d >> 5) & 7;
    m_cnt = nc; m_rel = nr;
    @(posedge clk); @(negedge clk);
    check(tag, int'(irq), m_irq, "irq");
    check(tag, int'(bus_rdata), expect_read(a), "rdata");
  endtask

  task automatic rd(input string tag, input int a);
    step(tag, 1'b0, a, 0, 1'b0);
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1, 0, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [7:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd("R1", 0); rd("R1", 1); rd("R1", 2); rd("R1", 3);
    // R2 mode field and reserved bits
    step("R2", 1'b1, 0, 8'h3F, 1'b0); rd("R2", 0);
    step("R2", 1'b1, 0, 8'h00, 1'b0);
    // R3 control register
    step("R3", 1'b1, 2, 8'hFF, 1'b0); rd("R3", 2);
    // R10 unused address
    step("R10", 1'b1, 3, 8'hAA, 1'b0); rd("R10", 0); rd("R10", 1); rd("R10", 2);
    step("R3", 1'b1, 2, 8'h00, 1'b0);
    // R6 stopped with steering set: write loads both, ticks ignored
    step("R6", 1'b1, 0, 8'h40, 1'b0);
    step("R6", 1'b1, 1, 5, 1'b0);
    ticks("R6", 3);
    // R4 / R5 run down and underflow
    step("R4", 1'b1, 0, 8'h80, 1'b0);
    ticks("R4", 5);
    ticks("R5", 2);
    // R7 running write-through
    step("R7", 1'b1, 1, 9, 1'b1);
    ticks("R7", 4);
    // R8 running, reload only
    step("R8", 1'b1, 0, 8'hC0, 1'b0);
    step("R8", 1'b1, 1, 2, 1'b0);
    ticks("R8", 8);
    // R9 same-cycle write and underflow
    step("R9", 1'b1, 0, 8'h80, 1'b0);
    step("R9", 1'b1, 1, 0, 1'b0);
    step("R9", 1'b1, 1, 7, 1'b1);
    ticks("R9", 2);
    step("R9", 1'b1, 1, 0, 1'b0);
    step("R9", 1'b1, 0, 8'hC0, 1'b0);
    ticks("R9", 1);
    step("R9", 1'b1, 1, 3, 1'b1);
    ticks("R9", 4);
    // R6 running flag with non-timer mode holds
    step("R6", 1'b1, 0, 8'hB0, 1'b0);
    ticks("R6", 4);
    step("R3", 1'b1, 2, 8'hE0, 1'b0);
    step("R3", 1'b1, 0, 8'h80, 1'b0);
    ticks("R3", 3);
    // mixed stimulus
    lf = 8'h5A;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (lf[2:0] == 3'd0)      step("R8", 1'b1, 0, {lf[7:6], 6'b0}, lf[3]);
      else if (lf[2:0] == 3'd1) step("R7", 1'b1, 1, {4'b0, lf[7:4]}, lf[3]);
      else                      step("R4", 1'b0, lf[4] ? 1 : 0, 0, lf[5] | lf[6]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule